// File: doc/BRIEF.md
# Chip-Select Gated Address Register

This block is a bank of rising-edge flip-flops that registers the command and address bits sent to a registered memory module. A data bus is captured into its output register whenever at least one of two active-low chip-select inputs is asserted. When both selects are deasserted (high), the data outputs keep their last value.

The primary chip select, the on-die-termination bit and the clock-enable bit are registered on every rising edge, whatever the selects are. This lets termination and power-down control reach the memory devices while the data outputs are parked. An active-low reset clears every output at once, without waiting for a clock. The data width is a parameter with a default of 25 bits, and each output is a single copy.

Top module: `csg_addr_reg`

## Requirements
- R1: On a rising edge of clk_i with rst_ni high, if cs_n_i is low or cs_aux_n_i is low, data_o takes the value data_i had at that edge.
- R2: On a rising edge of clk_i with rst_ni high, if cs_n_i and cs_aux_n_i are both high, data_o keeps its previous value.
- R3: On every rising edge of clk_i with rst_ni high, cs_n_o takes the value of cs_n_i, whatever cs_aux_n_i is.
- R4: On every rising edge of clk_i with rst_ni high, odt_o and cke_o take the values of odt_i and cke_i, including edges where both selects are high.
- R5: While rst_ni is low, data_o, cs_n_o, odt_o and cke_o are all low, and they go low as soon as rst_ni falls, without waiting for a clock edge.
- R6: After rst_ni rises, the first rising edge of clk_i captures the inputs under the rules of R1 to R4.
- R7: Outputs change only on a rising edge of clk_i or on reset assertion. Input changes between edges have no effect on the outputs until the next rising edge.
- R8: The data width is set by parameter DATA_W (default 25), and each data bit is registered independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | DATA_W | Command and address bits to register |
| cs_n_i | input | 1 | Primary chip select, active low |
| cs_aux_n_i | input | 1 | Secondary chip select, active low |
| odt_i | input | 1 | On-die-termination request |
| cke_i | input | 1 | Clock-enable request |
| data_o | output | DATA_W | Registered data bus |
| cs_n_o | output | 1 | Registered primary chip select |
| odt_o | output | 1 | Registered termination bit |
| cke_o | output | 1 | Registered clock-enable bit |

## Verification
Every registered result is due one rising edge after the inputs it depends on. The bench changes inputs at a falling edge and checks the outputs at the next falling edge, once that single rising edge has passed. Just after each input change, it also checks that the outputs still hold the previous values, which covers R7. Reset is checked one time unit after rst_ni falls between edges, with no clock edge in that window. The first capture after release is checked one edge after rst_ni rises.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int unsigned DEF_DATA_W = 25;
  localparam int unsigned CTL_W      = 3;  // cs_n, odt, cke

  typedef struct packed {
    logic cs_n;
    logic odt;
    logic cke;
  } ctl_t;
endpackage

// File: rtl/csg_sel_gate.sv
module csg_sel_gate (
  input  logic cs_n_i,
  input  logic cs_aux_n_i,
  output logic capture_o
);
  // Data is parked only when both selects are deasserted.
  assign capture_o = ~(cs_n_i & cs_aux_n_i);
endmodule

// File: rtl/csg_en_reg.sv
module csg_en_reg #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[b] <= 1'b0;
      else if (en_i) q_o[b] <= d_i[b];
    end
  end

  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o == $past(d_i)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/csg_addr_reg.sv
module csg_addr_reg
  import csg_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cs_n_i,
  input  logic              cs_aux_n_i,
  input  logic              odt_i,
  input  logic              cke_i,
  output logic [DATA_W-1:0] data_o,
  output logic              cs_n_o,
  output logic              odt_o,
  output logic              cke_o
);
  logic capture;
  ctl_t ctl_d, ctl_q;

  csg_sel_gate u_gate (
    .cs_n_i     (cs_n_i),
    .cs_aux_n_i (cs_aux_n_i),
    .capture_o  (capture)
  );

  csg_en_reg #(.WIDTH(DATA_W)) u_data_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (capture),
    .d_i    (data_i),
    .q_o    (data_o)
  );

  assign ctl_d = '{cs_n: cs_n_i, odt: odt_i, cke: cke_i};

  // Control bits never gated by the selects.
  csg_en_reg #(.WIDTH(CTL_W)) u_ctl_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .d_i    (ctl_d),
    .q_o    (ctl_q)
  );

  assign cs_n_o = ctl_q.cs_n;
  assign odt_o  = ctl_q.odt;
  assign cke_o  = ctl_q.cke;

  assert_cs_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cs_n_o == $past(cs_n_i)));

  assert_ctl_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && cs_aux_n_i) |=> (odt_o == $past(odt_i) && cke_o == $past(cke_i)));

  assert_reset_low_R5: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && !cs_n_o && !odt_o && !cke_o));
endmodule

// File: tb/csg_addr_reg_bench.sv
module csg_addr_reg_bench;
  localparam int unsigned W = 4;
  localparam int unsigned DEF_W = csg_pkg::DEF_DATA_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] d = '0;
  logic         cs_n = 1'b1, cs_aux_n = 1'b1, odt = 1'b0, cke = 1'b0;
  logic [W-1:0] q;
  logic         qcs, qodt, qcke;
  logic [DEF_W-1:0] dq_def;
  logic         dcs_def, dodt_def, dcke_def;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_d;
  logic         exp_cs, exp_odt, exp_cke;

  always #4 clk = ~clk;

  csg_addr_reg #(.DATA_W(W)) u_csg_addr_reg (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .cs_n_i(cs_n), .cs_aux_n_i(cs_aux_n),
    .odt_i(odt), .cke_i(cke), .data_o(q), .cs_n_o(qcs), .odt_o(qodt), .cke_o(qcke)
  );

  // Default-width instance: R8 checks the full 25-bit path.
  csg_addr_reg u_def (
    .clk_i(clk), .rst_ni(rst_n), .data_i({DEF_W{1'b1}} ^ {{(DEF_W-W){1'b0}}, d}),
    .cs_n_i(cs_n), .cs_aux_n_i(cs_aux_n), .odt_i(odt), .cke_i(cke),
    .data_o(dq_def), .cs_n_o(dcs_def), .odt_o(dodt_def), .cke_o(dcke_def)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, 32'(q), 32'(exp_d));
    chk(req, 32'(qcs), 32'(exp_cs));
    chk(req, 32'(qodt), 32'(exp_odt));
    chk(req, 32'(qcke), 32'(exp_cke));
  endtask

  // Called at a falling edge: drive, confirm no change before the edge, then check after it.
  task automatic step(input logic [W-1:0] nd, input logic ncs, input logic naux,
                      input logic nodt, input logic ncke, input string req);
    d = nd; cs_n = ncs; cs_aux_n = naux; odt = nodt; cke = ncke;
    #1 chk_all("R7");
    if (!(ncs && naux)) exp_d = nd;
    exp_cs = ncs; exp_odt = nodt; exp_cke = ncke;
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_d = '0; exp_cs = 0; exp_odt = 0; exp_cke = 0;
    repeat (2) @(negedge clk);
    chk_all("R5");
    rst_n = 1'b1;
    // First edge after release captures: R6
    step(4'hA, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
    chk("R8", 32'(dq_def), 32'({DEF_W{1'b1}} ^ {{(DEF_W-W){1'b0}}, 4'hA}));
    // Exhaustive sweep: sel pair, odt/cke, data
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i);
      step(v[7:4] ^ v[3:0], v[0], v[1], v[2], v[3],
           (v[0] && v[1]) ? "R2/R4" : (v[0] ? "R1/R3" : "R1/R3/R4"));
    end
    // Both selects high with control toggling: R4 and hold R2
    step(4'h5, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(4'hF, 1'b1, 1'b1, 1'b1, 1'b0, "R2/R4");
    step(4'h0, 1'b1, 1'b1, 1'b0, 1'b1, "R2/R4");
    step(4'h9, 1'b1, 1'b0, 1'b1, 1'b1, "R1/R3");
    chk("R8", 32'(dq_def), 32'({DEF_W{1'b1}} ^ {{(DEF_W-W){1'b0}}, 4'h9}));
    chk("R3", 32'(dcs_def), 32'd1);
    // Async reset between edges: R5
    rst_n = 1'b0;
    #1;
    exp_d = '0; exp_cs = 0; exp_odt = 0; exp_cke = 0;
    chk_all("R5");
    chk("R5", 32'(dq_def), 32'd0);
    @(negedge clk);
    d = 4'h7; cs_n = 1'b0; odt = 1'b1; cke = 1'b1;
    @(negedge clk);
    chk_all("R5");
    rst_n = 1'b1;
    step(4'h3, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule